// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. On every reference tick that reaches it with the timer running, a 32-bit addend is summed into a 32-bit fractional accumulator. Each time that sum wraps past 2^32, the time value moves forward by a programmed nanosecond step. Software holds the step constant and trims the clock rate by small amounts through the addend: for a trim of p parts per billion the addend becomes nominal ± nominal·p/10^9, up to roughly ±512000 ppb. A bypass mode skips the accumulator and adds the step on every tick.

Software uses a 32-bit word port with one-cycle registered reads. The port holds a control word, the two halves of the time value, the addend and the accumulator. A 64-bit time value spans two word accesses, so the block keeps both directions consistent. Reading the low half captures the high half for the next high read. A low-half write is parked until the high half is written, and then both halves load in the same cycle. The live time value is also driven on a parallel output for nearby compare and capture logic.

Top module: `tod_counter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the time value, accumulator, addend and `rd_data` are zero, and the control word reads 0x0000_0001.
- R2: With enable set and bypass clear, each cycle with `ref_tick` high sets the accumulator to (accumulator + addend) mod 2^32. The time value grows by the step field in that same cycle exactly when that sum carries past bit 31.
- R3: With enable and bypass both set, each `ref_tick` cycle adds the step field to the time value and leaves the accumulator unchanged.
- R4: With enable clear, or in a cycle with `ref_tick` low, neither the time value nor the accumulator changes, apart from port writes.
- R5: A read of address 1 returns bits 31:0 of the time value and captures bits 63:32. A later read of address 2 returns the captured bits, even if the counter has moved on since then.
- R6: A write to address 1 leaves the time value unchanged and parks the data. A write to address 2 loads {data, parked word} into the time value, and this load takes precedence over an advance in the same cycle.
- R7: A write to address 0 with bit 5 set clears the time value, the accumulator and the parked word, and returns the control word to 0x0000_0001. The addend is kept, and bit 5 is never stored.
- R8: Control word layout at address 0: step in nanoseconds at bits 25:16, bypass at bit 3, enable at bit 2, clock select at bits 1:0. All other bits read as zero.
- R9: The addend at address 3 and the accumulator at address 4 read back what was written. An accumulator write takes precedence over the addition in the same cycle. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R10: `rd_data` shows the addressed word in the cycle after `rd_en` and otherwise holds its value. `time_now` follows the time value with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe marking a reference clock edge |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| time_now | output | 64 | Current time value in nanoseconds |

## Verification
Every result of this block is due at the first rising edge after the inputs that cause it. A tick, a high-half write, a soft reset or an accumulator write is visible on `time_now` or in the stored state after that one edge. A read shows up on `rd_data` after the same single edge. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It compares `time_now`, and `rd_data` when a read was issued, on the next falling edge, so every check falls exactly one edge after its stimulus. Directed cases cover carry wrap, bypass, the shadowed high read across a high-half rollover, the parked low write, soft reset and unmapped addresses.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_ADDEND = 3'd3,
    A_ACCUM  = 3'd4
  } reg_addr_e;

  // control word bit positions
  localparam int B_SEL_LO  = 0;
  localparam int B_ENABLE  = 2;
  localparam int B_BYPASS  = 3;
  localparam int B_SOFTRST = 5;
  localparam int B_STEP_LO = 16;

  typedef struct packed {
    logic [9:0] step;
    logic       bypass;
    logic       enable;
    logic [1:0] clk_sel;
  } ctrl_t;

  localparam int STEP_W = 10;
  localparam logic [1:0] CLK_SEL_RST = 2'd1;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_addend,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] addend,
  output logic              soft_clr
);
  localparam ctrl_t CTRL_RST = '{step: '0, bypass: 1'b0, enable: 1'b0, clk_sel: CLK_SEL_RST};

  assign soft_clr = wr_ctrl & wdata[B_SOFTRST];

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ctrl <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl.step    <= wdata[B_STEP_LO +: STEP_W];
      ctrl.bypass  <= wdata[B_BYPASS];
      ctrl.enable  <= wdata[B_ENABLE];
      ctrl.clk_sel <= wdata[B_SEL_LO +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) addend <= '0;
    else if (wr_addend) addend <= wdata;
  end

  assert_soft_reset_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (ctrl == CTRL_RST));
  assert_addend_kept_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_addend |=> $stable(addend));
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic             wr,
  input  logic [ACC_W-1:0] wdata,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc,
  output logic             carry
);
  logic [ACC_W:0] sum;

  assign sum   = {1'b0, acc} + {1'b0, addend};
  assign carry = add_en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (wr)     acc <= wdata;
    else if (add_en) acc <= sum[ACC_W-1:0];
  end

  assert_acc_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !wr && !clr) |=> $stable(acc));
  assert_acc_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr) |=> (acc == $past(wdata)));
endmodule

// File: rtl/tod_count.sv
module tod_count #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                step_en,
  input  logic [STEP_W-1:0]   step,
  input  logic                lo_wr,
  input  logic                hi_wr,
  input  logic                lo_rd,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] count,
  output logic [DATA_W-1:0]   shadow_hi
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] parked_lo;

  always_ff @(posedge clk) begin
    if (rst || clr)   count <= '0;
    else if (hi_wr)   count <= {wdata, parked_lo};
    else if (step_en) count <= count + {{(CNT_W-STEP_W){1'b0}}, step};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) parked_lo <= '0;
    else if (lo_wr) parked_lo <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        shadow_hi <= '0;
    else if (lo_rd) shadow_hi <= count[CNT_W-1:DATA_W];
  end

  assert_step_add_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !hi_wr && !clr) |=>
      (count == $past(count) + {{(CNT_W-STEP_W){1'b0}}, $past(step)}));
  assert_count_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !hi_wr && !clr) |=> $stable(count));
  assert_low_parked_R6: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !step_en && !clr) |=> $stable(count));
  assert_shadow_capture_R5: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> (shadow_hi == $past(count[CNT_W-1:DATA_W])));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_tick,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] time_now
);
  localparam int CNT_W = 2 * DATA_W;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] shadow_hi;
  logic [CNT_W-1:0]  count;
  logic              soft_clr, carry, add_en, step_en;
  logic              wr_ctrl, wr_lo, wr_hi, wr_add, wr_acc, rd_lo;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_lo   = wr_en && (addr == A_CNT_LO);
  assign wr_hi   = wr_en && (addr == A_CNT_HI);
  assign wr_add  = wr_en && (addr == A_ADDEND);
  assign wr_acc  = wr_en && (addr == A_ACCUM);
  assign rd_lo   = rd_en && (addr == A_CNT_LO);

  assign add_en  = ctrl.enable & ref_tick & ~ctrl.bypass;
  assign step_en = ctrl.enable & ref_tick & (ctrl.bypass | carry);

  tod_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_addend(wr_add),
    .wdata(wr_data), .ctrl(ctrl), .addend(addend), .soft_clr(soft_clr)
  );

  tod_accum #(.ACC_W(DATA_W)) u_accum (
    .clk(clk), .rst(rst), .clr(soft_clr), .add_en(add_en), .wr(wr_acc),
    .wdata(wr_data), .addend(addend), .acc(acc), .carry(carry)
  );

  tod_count #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_count (
    .clk(clk), .rst(rst), .clr(soft_clr), .step_en(step_en), .step(ctrl.step),
    .lo_wr(wr_lo), .hi_wr(wr_hi), .lo_rd(rd_lo), .wdata(wr_data),
    .count(count), .shadow_hi(shadow_hi)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[B_STEP_LO +: STEP_W] = ctrl.step;
        rd_mux[B_BYPASS]            = ctrl.bypass;
        rd_mux[B_ENABLE]            = ctrl.enable;
        rd_mux[B_SEL_LO +: 2]       = ctrl.clk_sel;
      end
      A_CNT_LO: rd_mux = count[DATA_W-1:0];
      A_CNT_HI: rd_mux = shadow_hi;
      A_ADDEND: rd_mux = addend;
      A_ACCUM:  rd_mux = acc;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign time_now = count;

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  assert_rd_accum_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_ACCUM) |=> (rd_data == $past(acc)));
  assert_bypass_keeps_acc_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.bypass && ctrl.enable && !wr_en) |=> $stable(acc));
  assert_soft_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (time_now == '0 && acc == '0));
endmodule

// File: tb/test_tod_counter.sv
module test_tod_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] time_now;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [9:0]  m_step;
  logic        m_byp, m_en;
  logic [1:0]  m_sel;
  logic [31:0] m_add, m_acc, m_park, m_shadow, m_rd;
  logic [63:0] m_cnt;

  always #2.5 clk = ~clk;

  tod_counter i_tod_counter (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .time_now(time_now)
  );

  function automatic logic [31:0] ctrl_word();
    logic [31:0] v;
    v = '0;
    v[25:16] = m_step;
    v[3] = m_byp;
    v[2] = m_en;
    v[1:0] = m_sel;
    return v;
  endfunction

  function automatic logic [31:0] read_word(input logic [2:0] a);
    case (a)
      3'd0: return ctrl_word();
      3'd1: return m_cnt[31:0];
      3'd2: return m_shadow;
      3'd3: return m_add;
      3'd4: return m_acc;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_step = '0; m_byp = 0; m_en = 0; m_sel = 2'd1;
    m_add = '0; m_acc = '0; m_park = '0; m_shadow = '0; m_rd = '0; m_cnt = '0;
  endtask

  task automatic check64(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read
  task automatic cyc(input int op, input logic [2:0] a, input logic [31:0] d, input logic t, input string tag);
    logic [32:0] s;
    logic        stp, adv;
    logic [31:0] rv;
    wr_en = (op == 1); rd_en = (op == 2); addr = a; wr_data = d; ref_tick = t;
    @(posedge clk);
    rv  = read_word(a);
    s   = {1'b0, m_acc} + {1'b0, m_add};
    adv = m_en & t & ~m_byp;
    stp = m_en & t & (m_byp | s[32]);
    if (op == 2) begin
      m_rd = rv;
      if (a == 3'd1) m_shadow = m_cnt[63:32];
    end
    if (op == 1 && a == 3'd0 && d[5]) begin
      m_step = '0; m_byp = 0; m_en = 0; m_sel = 2'd1;
      m_acc = '0; m_cnt = '0; m_park = '0;
    end else begin
      if (op == 1 && a == 3'd4) m_acc = d;
      else if (adv) m_acc = s[31:0];
      if (op == 1 && a == 3'd2) m_cnt = {d, m_park};
      else if (stp) m_cnt = m_cnt + {54'd0, m_step};
      if (op == 1 && a == 3'd1) m_park = d;
      if (op == 1 && a == 3'd3) m_add = d;
      if (op == 1 && a == 3'd0) begin
        m_step = d[25:16]; m_byp = d[3]; m_en = d[2]; m_sel = d[1:0];
      end
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; ref_tick = 0;
    check64(tag, "time_now", time_now, m_cnt);
    if (op == 2) check64(tag, "rd_data", {32'd0, rd_data}, {32'd0, m_rd});
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    cyc(2, a, 32'd0, 1'b0, tag);
  endtask

  initial begin
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check64("R1", "time_now", time_now, 64'd0);
    check64("R1", "rd_data", {32'd0, rd_data}, 64'd0);
    rd_chk(3'd0, "R1");
    rd_chk(3'd3, "R1");
    rd_chk(3'd4, "R1");

    // R4: disabled, ticks do nothing
    cyc(1, 3'd3, 32'hC000_0000, 1'b0, "R9");
    for (int i = 0; i < 4; i++) cyc(0, 3'd0, 32'd0, 1'b1, "R4");
    rd_chk(3'd4, "R4");

    // R2: enable, step 25, addend 0xC0000000 -> carry pattern
    cyc(1, 3'd0, 32'h0019_0004, 1'b0, "R8");
    rd_chk(3'd0, "R8");
    for (int i = 0; i < 8; i++) cyc(0, 3'd0, 32'd0, 1'b1, "R2");
    cyc(0, 3'd0, 32'd0, 1'b0, "R4");
    rd_chk(3'd4, "R2");

    // R9: accumulator write near wrap wins over add
    cyc(1, 3'd4, 32'hFFFF_FFFF, 1'b1, "R9");
    rd_chk(3'd4, "R9");
    cyc(1, 3'd3, 32'h0000_0001, 1'b0, "R9");
    cyc(0, 3'd0, 32'd0, 1'b1, "R2");
    rd_chk(3'd4, "R2");

    // R6: parked low write, then high load during tick
    cyc(1, 3'd1, 32'hFFFF_FFF0, 1'b1, "R6");
    cyc(0, 3'd0, 32'd0, 1'b0, "R6");
    cyc(1, 3'd2, 32'h0000_0001, 1'b1, "R6");

    // R3 + R5: bypass across high-half rollover, shadowed read
    cyc(1, 3'd0, 32'h0020_000C, 1'b0, "R3");
    rd_chk(3'd1, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 3'd0, 32'd0, 1'b1, "R3");
    rd_chk(3'd4, "R3");
    rd_chk(3'd2, "R5");
    rd_chk(3'd1, "R5");
    rd_chk(3'd2, "R5");

    // R8: unused control bits, R9: unmapped addresses
    cyc(1, 3'd0, 32'hFFC0_FFD3, 1'b1, "R8");
    rd_chk(3'd0, "R8");
    cyc(1, 3'd5, 32'hDEAD_BEEF, 1'b0, "R9");
    rd_chk(3'd5, "R9");
    rd_chk(3'd7, "R9");
    cyc(0, 3'd0, 32'd0, 1'b0, "R10");
    check64("R10", "rd_data hold", {32'd0, rd_data}, {32'd0, m_rd});

    // R7: soft reset keeps addend
    cyc(1, 3'd0, 32'h0005_0024, 1'b1, "R7");
    rd_chk(3'd0, "R7");
    rd_chk(3'd3, "R7");
    rd_chk(3'd4, "R7");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0]  a;
      logic [31:0] d;
      r = int'($urandom_range(99));
      a = 3'($urandom_range(5));
      d = $urandom();
      if (a == 3'd0) begin
        d[5] = ($urandom_range(19) == 0);
        d[2] = ($urandom_range(7) != 0);
        d[25:16] = 10'($urandom_range(1023));
      end
      if (r < 55)      cyc(0, a, d, ($urandom_range(9) < 7), "R2");
      else if (r < 80) cyc(2, a, d, ($urandom_range(9) < 7), "R10");
      else             cyc(1, a, d, ($urandom_range(9) < 7), "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule